// File: doc/BRIEF.md
# Pause Frame Flow Control Controller

This block decides when a full-duplex Ethernet MAC has to transmit an IEEE 802.3x pause frame, and which pause time the frame carries. It compares the free space left in the receive buffer, counted in kilobytes, against two programmable 4-bit marks. When space gets short it asks for an XOFF frame (pause time FFFFh). Once that frame has actually left the transmitter and space has recovered past the second mark, it asks for an XON frame (pause time 0000h). The gap between the two marks gives the decision hysteresis, so one buffer crossing yields at most one request of each kind.

Software can also force either frame kind through two self-clearing bits. Each bit drops on its own once the matching frame has been sent. The transmit side sees a single request line with a pause time, held until it acknowledges completion. On the receive side the block keeps two views of pause frames from the link partner: a sticky flag that clears on read, and a registered copy of the live pause state.

Top module: `pause_fc_ctrl`

## Requirements
- R1: After a synchronous reset the high mark reads 3 and the low mark reads 8. The request line, both force bits and the sticky status are 0.
- R2: While automatic mode is on, free space strictly less than the high mark raises the request with pause time FFFFh. The request rises on the second clock edge after the condition is presented. Free space equal to or above the mark raises nothing.
- R3: A high mark of 0 means zero free space, so it never triggers an automatic XOFF.
- R4: An automatic XON (pause time 0000h) is requested only after the XOFF has been acknowledged, and only when free space is strictly greater than the low mark. Free space equal to the low mark gives no XON.
- R5: After the XOFF is acknowledged, space that stays below the high mark gives no further request until an XON has been sent.
- R6: With automatic mode off, no threshold condition raises a request.
- R7: A raised request holds both the request line and the pause time unchanged until the transmit-done pulse. The request line is 0 after the edge that samples transmit-done.
- R8: A pulse on a force input sets the matching force bit on the next edge. The request with the matching pause time follows one edge later. The bit clears on the edge that acknowledges its frame.
- R9: When both force bits are pending, the FFFFh frame is served first and the 0000h frame follows, with one idle cycle between them.
- R10: The sticky received-pause flag sets on a received-pause pulse and stays set until a read pulse clears it. A pulse and a read in the same cycle leave it set.
- R11: The live received-pause output equals the received-pause level input delayed by one clock.
- R12: A configuration write loads both marks on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| free_kb | input | FREE_W | Receive buffer free space in KB |
| cfg_we | input | 1 | Load both threshold marks |
| cfg_hi | input | THR_W | New high (XOFF) mark |
| cfg_lo | input | THR_W | New low (XON) mark |
| auto_en | input | 1 | Enable threshold-driven pause frames |
| force_xoff_set | input | 1 | Pulse: request an FFFFh frame |
| force_xon_set | input | 1 | Pulse: request a 0000h frame |
| tx_done | input | 1 | Transmit completion of the requested frame |
| rx_pause_evt | input | 1 | Pulse: a pause frame was received |
| rx_pause_live | input | 1 | Current received-pause state from the RX MAC |
| stat_rd | input | 1 | Read pulse that clears the sticky status |
| hi_thr_q | output | THR_W | Current high mark |
| lo_thr_q | output | THR_W | Current low mark |
| force_xoff_q | output | 1 | Pending forced FFFFh request |
| force_xon_q | output | 1 | Pending forced 0000h request |
| pause_req | output | 1 | Pause frame transmit request |
| pause_time | output | TIME_W | Pause time of the requested frame |
| rx_pause_sticky | output | 1 | Latched received-pause status |
| rx_pause_now | output | 1 | Registered live received-pause status |

## Verification
The bench sweeps every high mark against a range of free-space values. An off-by-one compare would fire at equality, and a mark of 0 would wrongly fire on an empty buffer. It then sweeps the low mark for XON after an acknowledged XOFF. This catches an XON that arms before the XOFF is sent, that fires at equality, or that repeats while space stays low. Forced frames are tested with both bits set at once, so a wrong priority or a bit that clears on the wrong completion shows up as a swapped pause time or a stuck bit. A sticky flag cleared by a read in the same cycle as a new event is caught as a lost event.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic [1:0] {
    WS_OPEN     = 2'd0,
    WS_XOFF_REQ = 2'd1,
    WS_XOFF_OUT = 2'd2,
    WS_XON_REQ  = 2'd3
  } water_st_t;

  typedef enum logic [2:0] {
    SRC_NONE  = 3'd0,
    SRC_FXOFF = 3'd1,
    SRC_FXON  = 3'd2,
    SRC_AXOFF = 3'd3,
    SRC_AXON  = 3'd4
  } pause_src_t;
endpackage

// File: rtl/pfc_thresh.sv
module pfc_thresh #(
  parameter int FREE_W = 5,
  parameter int THR_W  = 4,
  parameter int HI_RST = 3,
  parameter int LO_RST = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [THR_W-1:0]  cfg_hi,
  input  logic [THR_W-1:0]  cfg_lo,
  input  logic [FREE_W-1:0] free_kb,
  output logic [THR_W-1:0]  hi_q,
  output logic [THR_W-1:0]  lo_q,
  output logic              below_hi,
  output logic              above_lo
);
  localparam int CMP_W = (FREE_W > THR_W) ? FREE_W : THR_W;

  logic [CMP_W-1:0] free_x, hi_x, lo_x;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= THR_W'(HI_RST);
      lo_q <= THR_W'(LO_RST);
    end else if (cfg_we) begin
      hi_q <= cfg_hi;
      lo_q <= cfg_lo;
    end
  end

  always_comb begin
    free_x   = CMP_W'(free_kb);
    hi_x     = CMP_W'(hi_q);
    lo_x     = CMP_W'(lo_q);
    below_hi = free_x < hi_x;
    above_lo = free_x > lo_x;
  end
endmodule

// File: rtl/pfc_water_fsm.sv
module pfc_water_fsm
  import pfc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic auto_en,
  input  logic below_hi,
  input  logic above_lo,
  input  logic done_xoff,
  input  logic done_xon,
  input  logic auto_busy,
  output logic want_xoff,
  output logic want_xon
);
  water_st_t st, st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      WS_OPEN:
        if (auto_en && below_hi) st_nx = WS_XOFF_REQ;
      WS_XOFF_REQ:
        if (done_xoff) st_nx = WS_XOFF_OUT;
        else if (!auto_en && !auto_busy) st_nx = WS_OPEN;
      WS_XOFF_OUT:
        if (!auto_en) st_nx = WS_OPEN;
        else if (above_lo) st_nx = WS_XON_REQ;
      WS_XON_REQ:
        if (done_xon) st_nx = WS_OPEN;
        else if (!auto_en && !auto_busy) st_nx = WS_OPEN;
      default: st_nx = WS_OPEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= WS_OPEN;
    else     st <= st_nx;
  end

  assign want_xoff = (st == WS_XOFF_REQ);
  assign want_xon  = (st == WS_XON_REQ);
endmodule

// File: rtl/pfc_tx_arb.sv
module pfc_tx_arb
  import pfc_pkg::*;
#(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              force_xoff_set,
  input  logic              force_xon_set,
  input  logic              want_xoff,
  input  logic              want_xon,
  input  logic              tx_done,
  output logic              force_xoff_q,
  output logic              force_xon_q,
  output logic              pause_req,
  output logic [TIME_W-1:0] pause_time,
  output logic              done_xoff,
  output logic              done_xon,
  output logic              auto_busy
);
  localparam logic [TIME_W-1:0] T_XOFF = {TIME_W{1'b1}};
  localparam logic [TIME_W-1:0] T_XON  = '0;

  pause_src_t src;
  logic       fin;

  assign fin       = pause_req && tx_done;
  assign done_xoff = fin && (src == SRC_AXOFF);
  assign done_xon  = fin && (src == SRC_AXON);
  assign auto_busy = pause_req && ((src == SRC_AXOFF) || (src == SRC_AXON));

  always_ff @(posedge clk) begin
    if (rst) begin
      force_xoff_q <= 1'b0;
      force_xon_q  <= 1'b0;
    end else begin
      force_xoff_q <= (force_xoff_q && !(fin && src == SRC_FXOFF)) || force_xoff_set;
      force_xon_q  <= (force_xon_q  && !(fin && src == SRC_FXON))  || force_xon_set;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pause_req  <= 1'b0;
      pause_time <= T_XON;
      src        <= SRC_NONE;
    end else if (pause_req) begin
      if (tx_done) begin
        pause_req <= 1'b0;
        src       <= SRC_NONE;
      end
    end else if (force_xoff_q) begin
      pause_req  <= 1'b1;
      pause_time <= T_XOFF;
      src        <= SRC_FXOFF;
    end else if (force_xon_q) begin
      pause_req  <= 1'b1;
      pause_time <= T_XON;
      src        <= SRC_FXON;
    end else if (want_xoff) begin
      pause_req  <= 1'b1;
      pause_time <= T_XOFF;
      src        <= SRC_AXOFF;
    end else if (want_xon) begin
      pause_req  <= 1'b1;
      pause_time <= T_XON;
      src        <= SRC_AXON;
    end
  end
endmodule

// File: rtl/pfc_rx_status.sv
module pfc_rx_status (
  input  logic clk,
  input  logic rst,
  input  logic rx_pause_evt,
  input  logic rx_pause_live,
  input  logic stat_rd,
  output logic rx_pause_sticky,
  output logic rx_pause_now
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_pause_sticky <= 1'b0;
      rx_pause_now    <= 1'b0;
    end else begin
      rx_pause_sticky <= rx_pause_evt || (rx_pause_sticky && !stat_rd);
      rx_pause_now    <= rx_pause_live;
    end
  end
endmodule

// File: rtl/pause_fc_ctrl.sv
module pause_fc_ctrl #(
  parameter int FREE_W = 5,
  parameter int THR_W  = 4,
  parameter int TIME_W = 16,
  parameter int HI_RST = 3,
  parameter int LO_RST = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FREE_W-1:0] free_kb,
  input  logic              cfg_we,
  input  logic [THR_W-1:0]  cfg_hi,
  input  logic [THR_W-1:0]  cfg_lo,
  input  logic              auto_en,
  input  logic              force_xoff_set,
  input  logic              force_xon_set,
  input  logic              tx_done,
  input  logic              rx_pause_evt,
  input  logic              rx_pause_live,
  input  logic              stat_rd,
  output logic [THR_W-1:0]  hi_thr_q,
  output logic [THR_W-1:0]  lo_thr_q,
  output logic              force_xoff_q,
  output logic              force_xon_q,
  output logic              pause_req,
  output logic [TIME_W-1:0] pause_time,
  output logic              rx_pause_sticky,
  output logic              rx_pause_now
);
  logic below_hi, above_lo;
  logic want_xoff, want_xon;
  logic done_xoff, done_xon, auto_busy;

  pfc_thresh #(
    .FREE_W(FREE_W), .THR_W(THR_W), .HI_RST(HI_RST), .LO_RST(LO_RST)
  ) u_thresh (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_hi(cfg_hi), .cfg_lo(cfg_lo),
    .free_kb(free_kb), .hi_q(hi_thr_q), .lo_q(lo_thr_q),
    .below_hi(below_hi), .above_lo(above_lo)
  );

  pfc_water_fsm u_fsm (
    .clk(clk), .rst(rst), .auto_en(auto_en),
    .below_hi(below_hi), .above_lo(above_lo),
    .done_xoff(done_xoff), .done_xon(done_xon), .auto_busy(auto_busy),
    .want_xoff(want_xoff), .want_xon(want_xon)
  );

  pfc_tx_arb #(.TIME_W(TIME_W)) u_arb (
    .clk(clk), .rst(rst),
    .force_xoff_set(force_xoff_set), .force_xon_set(force_xon_set),
    .want_xoff(want_xoff), .want_xon(want_xon), .tx_done(tx_done),
    .force_xoff_q(force_xoff_q), .force_xon_q(force_xon_q),
    .pause_req(pause_req), .pause_time(pause_time),
    .done_xoff(done_xoff), .done_xon(done_xon), .auto_busy(auto_busy)
  );

  pfc_rx_status u_rx (
    .clk(clk), .rst(rst), .rx_pause_evt(rx_pause_evt),
    .rx_pause_live(rx_pause_live), .stat_rd(stat_rd),
    .rx_pause_sticky(rx_pause_sticky), .rx_pause_now(rx_pause_now)
  );
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
  parameter int TIME_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              force_xoff_set,
  input logic              force_xon_set,
  input logic              tx_done,
  input logic              rx_pause_evt,
  input logic              rx_pause_live,
  input logic              stat_rd,
  input logic              force_xoff_q,
  input logic              force_xon_q,
  input logic              pause_req,
  input logic [TIME_W-1:0] pause_time,
  input logic              rx_pause_sticky,
  input logic              rx_pause_now
);
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (pause_req && !tx_done) |=> (pause_req && $stable(pause_time)));

  assert_req_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (pause_req && tx_done) |=> !pause_req);

  assert_time_legal_R2: assert property (@(posedge clk) disable iff (rst)
    pause_req |-> (pause_time == {TIME_W{1'b1}} || pause_time == '0));

  assert_fxoff_src_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(force_xoff_q) |-> $past(force_xoff_set));

  assert_fxon_src_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(force_xon_q) |-> $past(force_xon_set));

  assert_sticky_set_R10: assert property (@(posedge clk) disable iff (rst)
    rx_pause_evt |=> rx_pause_sticky);

  assert_sticky_keep_R10: assert property (@(posedge clk) disable iff (rst)
    (rx_pause_sticky && !stat_rd) |=> rx_pause_sticky);

  assert_live_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rx_pause_now == $past(rx_pause_live)));
endmodule

bind pause_fc_ctrl pfc_checker #(.TIME_W(TIME_W)) u_pfc_chk (
  .clk(clk), .rst(rst), .force_xoff_set(force_xoff_set),
  .force_xon_set(force_xon_set), .tx_done(tx_done),
  .rx_pause_evt(rx_pause_evt), .rx_pause_live(rx_pause_live),
  .stat_rd(stat_rd), .force_xoff_q(force_xoff_q), .force_xon_q(force_xon_q),
  .pause_req(pause_req), .pause_time(pause_time),
  .rx_pause_sticky(rx_pause_sticky), .rx_pause_now(rx_pause_now)
);

// File: tb/test_pause_fc_ctrl.sv
module test_pause_fc_ctrl;
  localparam int FREE_W = 5;
  localparam int THR_W  = 4;
  localparam int TIME_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [FREE_W-1:0] free_kb = '0;
  logic              cfg_we = 1'b0;
  logic [THR_W-1:0]  cfg_hi = '0, cfg_lo = '0;
  logic              auto_en = 1'b0;
  logic              force_xoff_set = 1'b0, force_xon_set = 1'b0;
  logic              tx_done = 1'b0;
  logic              rx_pause_evt = 1'b0, rx_pause_live = 1'b0, stat_rd = 1'b0;
  logic [THR_W-1:0]  hi_thr_q, lo_thr_q;
  logic              force_xoff_q, force_xon_q, pause_req;
  logic [TIME_W-1:0] pause_time;
  logic              rx_pause_sticky, rx_pause_now;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pause_fc_ctrl #(.FREE_W(FREE_W), .THR_W(THR_W), .TIME_W(TIME_W)) i_pause_fc_ctrl (
    .clk(clk), .rst(rst), .free_kb(free_kb), .cfg_we(cfg_we), .cfg_hi(cfg_hi),
    .cfg_lo(cfg_lo), .auto_en(auto_en), .force_xoff_set(force_xoff_set),
    .force_xon_set(force_xon_set), .tx_done(tx_done), .rx_pause_evt(rx_pause_evt),
    .rx_pause_live(rx_pause_live), .stat_rd(stat_rd), .hi_thr_q(hi_thr_q),
    .lo_thr_q(lo_thr_q), .force_xoff_q(force_xoff_q), .force_xon_q(force_xon_q),
    .pause_req(pause_req), .pause_time(pause_time),
    .rx_pause_sticky(rx_pause_sticky), .rx_pause_now(rx_pause_now)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack();
    tx_done = 1'b1;
    step(1);
    tx_done = 1'b0;
  endtask

  // Load thresholds with automatic mode off, leaving the threshold FSM idle.
  task automatic setup(input int hi, input int lo, input int fr);
    auto_en = 1'b0;
    cfg_we  = 1'b1;
    cfg_hi  = THR_W'(hi);
    cfg_lo  = THR_W'(lo);
    free_kb = FREE_W'(fr);
    step(1);
    cfg_we = 1'b0;
    step(1);
  endtask

  initial begin
    step(2);
    rst = 1'b0;
    step(1);
    // R1: reset values
    chk("R1 hi", hi_thr_q, 3);
    chk("R1 lo", lo_thr_q, 8);
    chk("R1 req", pause_req, 0);
    chk("R1 fxoff", force_xoff_q, 0);
    chk("R1 fxon", force_xon_q, 0);
    chk("R1 sticky", rx_pause_sticky, 0);

    // R12: configuration write
    setup(5, 11, 20);
    chk("R12 hi", hi_thr_q, 5);
    chk("R12 lo", lo_thr_q, 11);

    // R2/R3: sweep high mark against free space
    for (int hi = 0; hi < 16; hi++) begin
      for (int fr = 0; fr < 20; fr++) begin
        setup(hi, 15, fr);
        auto_en = 1'b1;
        step(2);
        chk(hi == 0 ? "R3 req" : "R2 req", pause_req, (fr < hi) ? 1 : 0);
        if (pause_req) begin
          chk("R2 time", pause_time, 16'hFFFF);
          ack();
          chk("R7 drop", pause_req, 0);
        end
      end
    end

    // R6: automatic mode off, deep below the high mark
    setup(10, 15, 0);
    step(5);
    chk("R6 no req", pause_req, 0);

    // R7: request held while not acknowledged, even if space recovers
    setup(4, 6, 1);
    auto_en = 1'b1;
    step(2);
    chk("R7 req", pause_req, 1);
    free_kb = 5'd12;
    step(4);
    chk("R7 hold req", pause_req, 1);
    chk("R4 still xoff before ack", pause_time, 16'hFFFF);
    ack();
    chk("R7 drop", pause_req, 0);
    step(2);
    chk("R4 xon after ack", pause_req, 1);
    chk("R4 xon time", pause_time, 0);
    ack();

    // R4/R5: sweep low mark crossing after an acknowledged XOFF
    for (int lo = 4; lo < 16; lo += 3) begin
      for (int fr = 0; fr < 20; fr++) begin
        setup(3, lo, 1);
        auto_en = 1'b1;
        step(2);
        chk("R2 xoff", pause_req, 1);
        ack();
        free_kb = FREE_W'(fr);
        step(3);
        if (fr < 3)
          chk("R5 no repeat", pause_req, 0);
        else
          chk("R4 xon", pause_req, (fr > lo) ? 1 : 0);
        if (pause_req) begin
          chk("R4 xon time", pause_time, 0);
          ack();
        end
      end
    end

    // R8/R9: both force bits at once, automatic mode off
    setup(3, 8, 20);
    force_xoff_set = 1'b1;
    force_xon_set  = 1'b1;
    step(1);
    force_xoff_set = 1'b0;
    force_xon_set  = 1'b0;
    chk("R8 fxoff set", force_xoff_q, 1);
    chk("R8 fxon set", force_xon_q, 1);
    step(1);
    chk("R9 first req", pause_req, 1);
    chk("R9 first FFFF", pause_time, 16'hFFFF);
    step(3);
    chk("R7 force hold", pause_req, 1);
    ack();
    chk("R8 fxoff cleared", force_xoff_q, 0);
    chk("R8 fxon kept", force_xon_q, 1);
    chk("R9 idle gap", pause_req, 0);
    step(1);
    chk("R9 second req", pause_req, 1);
    chk("R9 second 0000", pause_time, 0);
    ack();
    chk("R8 fxon cleared", force_xon_q, 0);
    step(3);
    chk("R8 no extra", pause_req, 0);

    // R10: sticky status
    rx_pause_evt = 1'b1;
    step(1);
    rx_pause_evt = 1'b0;
    step(3);
    chk("R10 sticky held", rx_pause_sticky, 1);
    stat_rd = 1'b1;
    step(1);
    stat_rd = 1'b0;
    chk("R10 cleared", rx_pause_sticky, 0);
    rx_pause_evt = 1'b1;
    stat_rd = 1'b1;
    step(1);
    rx_pause_evt = 1'b0;
    stat_rd = 1'b0;
    chk("R10 evt wins", rx_pause_sticky, 1);

    // R11: live status, one clock late
    rx_pause_live = 1'b1;
    chk("R11 before edge", rx_pause_now, 0);
    step(1);
    chk("R11 rise", rx_pause_now, 1);
    rx_pause_live = 1'b0;
    step(1);
    chk("R11 fall", rx_pause_now, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule